// File: doc/BRIEF.md
# Windowed Link Power and Bandwidth Controller

This block supervises a group of optical links that share a pool of wavelength channels. Every link reports, each cycle, whether it carried traffic and whether its transmit buffer held data. The controller cuts time into back-to-back windows of `WIN_LEN` cycles. For each window it counts the busy cycles of every link and sorts the link into a low, mid or high utilization class.

When a window closes, a short background exchange derives the next settings from that window's statistics. The exchange runs as request, response, commit and acknowledge stages between the central sequencer and one monitor per link. Each link's power code moves one step toward the level its class calls for. Spare channels of lightly used links are handed to heavily used links that showed a backlog.

Counting never pauses during the exchange, so link traffic is neither stalled nor lost. The power code drives the link's bit-rate and supply-voltage setting. The channel map tells the optical switch fabric which link owns each wavelength.

Top module: `lpbc_ctrl`

## Requirements
- R1: Windows are `WIN_LEN` cycles long and follow each other without gaps. The first window starts on the first clock edge after reset is released. Every busy cycle counts toward the window it falls in, including cycles during which a reconfiguration exchange is running.
- R2: A link whose busy count is below `LO_TH` is low class. A count from `LO_TH` up to `HI_TH`-1 is mid class. A count of `HI_TH` or more is high class, so a count equal to a threshold takes the higher class.
- R3: Power codes are 0 for low, 1 for mid and 2 for high. The field for link l is `pwr_lvl[2l+1:2l]`, and its target is the code of the link's class.
- R4: Within one window a power code changes by at most one step toward its target, and it stays put when it already equals the target.
- R5: `ch_owner[c*LW +: LW]` holds the index of the link owning channel c. Channels are scanned from index 0 upward. A channel whose owner is low class is moved to a receiver link, meaning a link that is high class and raised `buf_occ` in at least one cycle of that window. Receivers are served round robin, starting from the lowest-index receiver.
- R6: A donor gives up a channel only while it still holds more than one. Mid and high links never lose channels. Without any receiver the map stays unchanged.
- R7: New settings appear on the outputs exactly four clock edges after the last edge of a window, one edge each for request, response, commit and acknowledge. The outputs hold their values at every other time.
- R8: Reset sets every power code to 1 (mid) and gives channel c to link c mod `N_LINKS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| link_busy | input | N_LINKS | Per-link busy indication for the current cycle |
| buf_occ | input | N_LINKS | Per-link transmit buffer non-empty flag |
| pwr_lvl | output | 2*N_LINKS | Per-link power code (bit rate and supply voltage setting) |
| ch_owner | output | N_CH*LW | Owning link index for every wavelength channel |

## Verification
The assertions take for granted that `WIN_LEN` is at least 8, so that an exchange always ends before the next window boundary. They also assume the thresholds are ordered with `LO_TH` ≤ `HI_TH` ≤ `WIN_LEN` and that `N_LINKS` is a power of two, which keeps every owner index valid. The bench keeps the default parameters, which meet all three conditions, and holds reset from time zero. It changes `link_busy` and `buf_occ` only on falling edges and lines its busy patterns up with the window grid, so each count is known exactly.

// File: rtl/lpbc_pkg.sv
package lpbc_pkg;

  typedef enum logic [1:0] {
    CLS_LO  = 2'd0,
    CLS_MID = 2'd1,
    CLS_HI  = 2'd2
  } util_cls_e;

  localparam logic [1:0] PWR_MID = 2'd1;

  // Sort a window's busy count into a class; ties go upward.
  function automatic util_cls_e classify(input int unsigned busy_cnt,
                                         input int unsigned lo_th,
                                         input int unsigned hi_th);
    if (busy_cnt >= hi_th) return CLS_HI;
    if (busy_cnt >= lo_th) return CLS_MID;
    return CLS_LO;
  endfunction

  // Move the power code one step toward the class target.
  function automatic logic [1:0] next_pwr(input logic [1:0] cur, input util_cls_e cls);
    logic [1:0] tgt;
    tgt = 2'(cls);
    if (tgt > cur) return cur + 2'd1;
    if (tgt < cur) return cur - 2'd1;
    return cur;
  endfunction

endpackage

// File: rtl/lpbc_link_mon.sv
module lpbc_link_mon
  import lpbc_pkg::*;
#(
  parameter int unsigned WIN_LEN = 32,
  parameter int unsigned LO_TH   = 8,
  parameter int unsigned HI_TH   = 24
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      busy,
  input  logic      buf_occ,
  input  logic      win_end,
  input  logic      stat_req,
  input  logic      cmt_req,
  output util_cls_e cls,
  output logic      backlog,
  output logic      rsp_vld,
  output logic      cmt_ack
);

  localparam int unsigned CNT_W = $clog2(WIN_LEN + 1);

  logic [CNT_W-1:0] busy_cnt;
  logic [CNT_W-1:0] snap_cnt;
  logic             seen_occ;
  logic             snap_occ;
  logic [CNT_W-1:0] cnt_inc;

  assign cnt_inc = busy_cnt + {{(CNT_W-1){1'b0}}, busy};

  // Statistics: counting never stops, boundaries only snapshot and clear.
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_cnt <= '0;
      snap_cnt <= '0;
      seen_occ <= 1'b0;
      snap_occ <= 1'b0;
    end else if (win_end) begin
      snap_cnt <= cnt_inc;
      busy_cnt <= '0;
      snap_occ <= seen_occ | buf_occ;
      seen_occ <= 1'b0;
    end else begin
      busy_cnt <= cnt_inc;
      seen_occ <= seen_occ | buf_occ;
    end
  end

  // Link-side responder for the request and commit stages.
  always_ff @(posedge clk) begin
    if (rst) begin
      cls     <= CLS_MID;
      backlog <= 1'b0;
      rsp_vld <= 1'b0;
      cmt_ack <= 1'b0;
    end else begin
      rsp_vld <= stat_req;
      cmt_ack <= cmt_req;
      if (stat_req) begin
        cls     <= classify(32'(snap_cnt), LO_TH, HI_TH);
        backlog <= snap_occ;
      end
    end
  end

  // R1: the running count never reaches a full window
  a_r1_cnt_in_window: assert property (@(posedge clk) disable iff (rst)
    busy_cnt < CNT_W'(WIN_LEN));

  // R7: a response only ever follows a request
  a_r7_rsp_after_req: assert property (@(posedge clk) disable iff (rst)
    rsp_vld |-> $past(stat_req));

endmodule

// File: rtl/lpbc_chan_plan.sv
module lpbc_chan_plan
  import lpbc_pkg::*;
#(
  parameter int unsigned N_LINKS = 4,
  parameter int unsigned N_CH    = 8,
  parameter int unsigned LW      = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 plan_en,
  input  util_cls_e            cls [N_LINKS],
  input  logic [N_LINKS-1:0]   backlog,
  input  logic [N_CH*LW-1:0]   own_cur,
  output logic [N_CH*LW-1:0]   own_next
);

  logic [N_LINKS-1:0] rx_ok;

  for (genvar l = 0; l < N_LINKS; l++) begin : g_rx
    assign rx_ok[l] = (cls[l] == CLS_HI) && backlog[l];
  end

  // Ascending channel scan; donors keep one channel, receivers rotate.
  always_comb begin
    int   held [N_LINKS];
    int   ptr;
    int   src;
    int   dst;
    logic found;
    own_next = own_cur;
    ptr      = 0;
    src      = 0;
    dst      = 0;
    found    = 1'b0;
    for (int l = 0; l < N_LINKS; l++) held[l] = 0;
    for (int c = 0; c < N_CH; c++) begin
      src       = int'(own_cur[c*LW +: LW]);
      held[src] = held[src] + 1;
    end
    for (int c = 0; c < N_CH; c++) begin
      src = int'(own_cur[c*LW +: LW]);
      if ((|rx_ok) && (cls[src] == CLS_LO) && (held[src] > 1)) begin
        found = 1'b0;
        dst   = 0;
        for (int j = 0; j < N_LINKS; j++) begin
          if (!found && rx_ok[(ptr + j) % N_LINKS]) begin
            found = 1'b1;
            dst   = (ptr + j) % N_LINKS;
          end
        end
        own_next[c*LW +: LW] = LW'(dst);
        held[src]            = held[src] - 1;
        ptr                  = (dst + 1) % N_LINKS;
      end
    end
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_move_chk
    logic [LW-1:0] old_o;
    logic [LW-1:0] new_o;
    assign old_o = own_cur[c*LW +: LW];
    assign new_o = own_next[c*LW +: LW];
    // R5: a moved channel leaves a low link for a backlogged high link
    a_r5_donor_to_receiver: assert property (@(posedge clk) disable iff (rst)
      (plan_en && (old_o != new_o)) |->
        ((cls[old_o] == CLS_LO) && (cls[new_o] == CLS_HI) && backlog[new_o]));
  end

endmodule

// File: rtl/lpbc_ctrl.sv
module lpbc_ctrl
  import lpbc_pkg::*;
#(
  parameter int unsigned N_LINKS = 4,
  parameter int unsigned N_CH    = 8,
  parameter int unsigned WIN_LEN = 32,
  parameter int unsigned LO_TH   = 8,
  parameter int unsigned HI_TH   = 24,
  localparam int unsigned LW     = (N_LINKS > 1) ? $clog2(N_LINKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_LINKS-1:0]   link_busy,
  input  logic [N_LINKS-1:0]   buf_occ,
  output logic [2*N_LINKS-1:0] pwr_lvl,
  output logic [N_CH*LW-1:0]   ch_owner
);

  localparam int unsigned WCW = $clog2(WIN_LEN);

  typedef enum logic [2:0] {ST_IDLE, ST_REQ, ST_RSP, ST_CMT, ST_ACK} rc_state_e;

  rc_state_e            state;
  logic [WCW-1:0]       wcnt;
  logic                 win_end;
  logic                 stat_req;
  logic                 cmt_req;
  logic                 plan_en;
  logic                 apply_evt;
  util_cls_e            cls_v [N_LINKS];
  logic [N_LINKS-1:0]   backlog_v;
  logic [N_LINKS-1:0]   rsp_v;
  logic [N_LINKS-1:0]   ack_v;
  logic [N_CH*LW-1:0]   own_plan;
  logic [2*N_LINKS-1:0] pend_pwr;
  logic [N_CH*LW-1:0]   pend_own;
  logic [2*N_LINKS-1:0] pwr_q;
  logic [N_CH*LW-1:0]   own_q;

  // Window grid
  assign win_end = (wcnt == WCW'(WIN_LEN - 1));

  always_ff @(posedge clk) begin
    if (rst || win_end) wcnt <= '0;
    else                wcnt <= wcnt + 1'b1;
  end

  // Named stage events
  assign stat_req  = (state == ST_REQ);
  assign cmt_req   = (state == ST_CMT);
  assign plan_en   = (state == ST_RSP) && (&rsp_v);
  assign apply_evt = (state == ST_ACK) && (&ack_v);

  for (genvar l = 0; l < N_LINKS; l++) begin : g_link
    lpbc_link_mon #(
      .WIN_LEN(WIN_LEN), .LO_TH(LO_TH), .HI_TH(HI_TH)
    ) mon_i (
      .clk(clk), .rst(rst), .busy(link_busy[l]), .buf_occ(buf_occ[l]),
      .win_end(win_end), .stat_req(stat_req), .cmt_req(cmt_req),
      .cls(cls_v[l]), .backlog(backlog_v[l]), .rsp_vld(rsp_v[l]), .cmt_ack(ack_v[l])
    );
  end

  lpbc_chan_plan #(.N_LINKS(N_LINKS), .N_CH(N_CH), .LW(LW)) plan_i (
    .clk(clk), .rst(rst), .plan_en(plan_en), .cls(cls_v), .backlog(backlog_v),
    .own_cur(own_q), .own_next(own_plan)
  );

  // Reconfiguration sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      pend_pwr <= '0;
      pend_own <= '0;
      for (int l = 0; l < N_LINKS; l++) pwr_q[2*l +: 2] <= PWR_MID;
      for (int c = 0; c < N_CH; c++)    own_q[c*LW +: LW] <= LW'(c % N_LINKS);
    end else begin
      case (state)
        ST_IDLE: if (win_end) state <= ST_REQ;
        ST_REQ:  state <= ST_RSP;
        ST_RSP:  if (plan_en) begin
          for (int l = 0; l < N_LINKS; l++)
            pend_pwr[2*l +: 2] <= next_pwr(pwr_q[2*l +: 2], cls_v[l]);
          pend_own <= own_plan;
          state    <= ST_CMT;
        end
        ST_CMT:  state <= ST_ACK;
        ST_ACK:  if (apply_evt) begin
          pwr_q <= pend_pwr;
          own_q <= pend_own;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign pwr_lvl  = pwr_q;
  assign ch_owner = own_q;

  // R1: a window boundary never lands inside an exchange
  a_r1_boundary_idle: assert property (@(posedge clk) disable iff (rst)
    win_end |-> (state == ST_IDLE));

  // R7: outputs move only on an acknowledged commit
  a_r7_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
    !apply_evt |=> ($stable(pwr_lvl) && $stable(ch_owner)));

  a_r7_ack_after_commit: assert property (@(posedge clk) disable iff (rst)
    apply_evt |-> $past(cmt_req));

  for (genvar l = 0; l < N_LINKS; l++) begin : g_out_chk
    int owned_n;
    always_comb begin
      owned_n = 0;
      for (int c = 0; c < N_CH; c++)
        if (ch_owner[c*LW +: LW] == LW'(l)) owned_n = owned_n + 1;
    end
    // R6: every link always owns a channel
    a_r6_keep_one: assert property (@(posedge clk) disable iff (rst)
      owned_n != 0);
    // R4: at most one power step per update
    a_r4_one_step: assert property (@(posedge clk) disable iff (rst)
      (pwr_lvl[2*l +: 2] != $past(pwr_lvl[2*l +: 2])) |->
        ((pwr_lvl[2*l +: 2] == $past(pwr_lvl[2*l +: 2]) + 2'd1) ||
         (pwr_lvl[2*l +: 2] + 2'd1 == $past(pwr_lvl[2*l +: 2]))));
    // R3: codes stay within low..high
    a_r3_code_range: assert property (@(posedge clk) disable iff (rst)
      pwr_lvl[2*l +: 2] != 2'd3);
  end

endmodule

// File: tb/lpbc_ctrl_tb_top.sv
module lpbc_ctrl_tb_top;

  localparam int NL  = 4;
  localparam int NC  = 8;
  localparam int WIN = 32;
  localparam int LWB = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NL-1:0]     link_busy = '0;
  logic [NL-1:0]     buf_occ = '0;
  logic [2*NL-1:0]   pwr_lvl;
  logic [NC*LWB-1:0] ch_owner;

  int checks = 0;
  int errors = 0;
  int win_busy [NL];
  bit win_buf  [NL];
  logic [2*NL-1:0]   pre_pwr, post_pwr;
  logic [NC*LWB-1:0] pre_own, post_own;

  always #2 clk = ~clk;

  lpbc_ctrl #(.N_LINKS(NL), .N_CH(NC), .WIN_LEN(WIN), .LO_TH(8), .HI_TH(24)) dut_i (
    .clk(clk), .rst(rst), .link_busy(link_busy), .buf_occ(buf_occ),
    .pwr_lvl(pwr_lvl), .ch_owner(ch_owner)
  );

  function automatic logic [2*NL-1:0] pv(int a, int b, int c, int d);
    return {2'(d), 2'(c), 2'(b), 2'(a)};
  endfunction

  function automatic logic [NC*LWB-1:0] ov(int c0, int c1, int c2, int c3,
                                           int c4, int c5, int c6, int c7);
    return {2'(c7), 2'(c6), 2'(c5), 2'(c4), 2'(c3), 2'(c2), 2'(c1), 2'(c0)};
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic set_win(int a, int b, int c, int d, bit ba, bit bb, bit bc, bit bd);
    win_busy[0] = a;  win_busy[1] = b;  win_busy[2] = c;  win_busy[3] = d;
    win_buf[0]  = ba; win_buf[1]  = bb; win_buf[2]  = bc; win_buf[3]  = bd;
  endtask

  // One window aligned to the grid; also captures the previous window's update.
  task automatic run_window();
    for (int i = 0; i < WIN; i++) begin
      for (int l = 0; l < NL; l++) begin
        link_busy[l] = (i < win_busy[l]);
        buf_occ[l]   = win_buf[l] && (i == 5);
      end
      @(negedge clk);
      if (i == 2) begin pre_pwr = pwr_lvl;  pre_own = ch_owner;  end
      if (i == 3) begin post_pwr = pwr_lvl; post_own = ch_owner; end
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    link_busy = '0;
    buf_occ = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R8 reset power", 32'(pwr_lvl), 32'(pv(1,1,1,1)));
    check("R8 reset map", 32'(ch_owner), 32'(ov(0,1,2,3,0,1,2,3)));
  endtask

  task automatic t_thresholds();
    do_reset();
    set_win(7, 8, 23, 24, 0, 0, 0, 0);
    run_window();
    set_win(32, 8, 0, 0, 0, 0, 0, 0);
    run_window();
    check("R7 hold before ack", 32'(pre_pwr), 32'(pv(1,1,1,1)));
    check("R2 R3 threshold classes", 32'(post_pwr), 32'(pv(0,1,1,2)));
    check("R5 high without backlog gets nothing", 32'(post_own), 32'(ov(0,1,2,3,0,1,2,3)));
    set_win(0, 0, 0, 0, 0, 0, 0, 0);
    run_window();
    check("R7 hold previous settings", 32'(pre_pwr), 32'(pv(0,1,1,2)));
    check("R4 single step per window", 32'(post_pwr), 32'(pv(1,1,0,1)));
    check("R1 busy during exchange counted", 32'(post_pwr[3:2]), 32'd1);
  endtask

  task automatic t_realloc();
    do_reset();
    set_win(0, 32, 16, 16, 0, 1, 0, 0);
    run_window();
    run_window();
    check("R5 donation to backlogged high link", 32'(post_own), 32'(ov(1,1,2,3,0,1,2,3)));
    check("R3 power targets", 32'(post_pwr), 32'(pv(0,2,1,1)));
    set_win(0, 0, 0, 0, 0, 0, 0, 0);
    run_window();
    check("R7 map held before ack", 32'(pre_own), 32'(ov(1,1,2,3,0,1,2,3)));
    check("R6 donor keeps last channel", 32'(post_own), 32'(ov(1,1,2,3,0,1,2,3)));
    check("R4 power at target stays", 32'(post_pwr), 32'(pv(0,2,1,1)));
  endtask

  task automatic t_multi();
    do_reset();
    set_win(0, 0, 32, 32, 0, 0, 1, 1);
    run_window();
    set_win(0, 0, 0, 0, 0, 0, 0, 0);
    run_window();
    check("R5 round robin receivers", 32'(post_own), 32'(ov(2,3,2,3,0,1,2,3)));
    check("R3 mixed power", 32'(post_pwr), 32'(pv(0,0,2,2)));
    run_window();
    check("R6 no receiver keeps map", 32'(post_own), 32'(ov(2,3,2,3,0,1,2,3)));
    check("R4 step down from high", 32'(post_pwr), 32'(pv(0,0,1,1)));
  endtask

  initial begin
    #(4 * 20000);
    errors++;
    $display("FAIL watchdog R7: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_thresholds();
    t_realloc();
    t_multi();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule